// File: doc/BRIEF.md
# Per-Channel Gamma Correction Lookup

This block applies a gamma curve to an RGB pixel stream. Each colour channel owns a table of 2^8 entries, each 10 bits wide. While correction is on, every 8-bit component of an incoming pixel indexes its own channel's table, and the stored 10-bit word leaves the block one cycle later. While correction is off, the component passes through scaled to 10 bits (shifted left by two), also one cycle later.

Host software fills the tables through three register ports: a control/status port, an address port and a data port. It clears the enable bit first. It then writes the address port with a start index, a channel mask and an auto-increment flag. After that it streams table words through the data port. Two ready flags throttle the host: after each accepted address or data write they stay low for a fixed number of clock cycles, which gives the table storage time to commit. A read request bit in the address port fetches one entry back to the data port. The read-ready flag reports when that entry is available.

Register reads are registered: the word selected by `regSel` while `regRd` is high appears on `regRdata` after the next rising clock edge.

Top module: `gamma_lut`

## Requirements
- R1: After reset, `outValid` is 0 and all three outputs are 0. The control port reads 0x30 (only write-ready at bit 4 and address-ready at bit 5 are set), and the address port reads 0.
- R2: With enable (control bit 0) clear, each component appears on its output as input×4, one cycle after `pixValid` is sampled high. `outValid` is `pixValid` delayed by one cycle.
- R3: With enable set, each output is the entry of its own channel's table indexed by that channel's input, one cycle after `pixValid` is sampled high.
- R4: Each accepted data-port write stores bits 9:0 into the addressed entry. If auto-increment (address bit 11) is set, the index then advances by one and wraps from 255 to 0. If the bit is clear, the index stays where it is.
- R5: An accepted address or data write drops write-ready (control bit 4) and address-ready (control bit 5) for exactly 2 clock cycles. While these flags are low, address writes are ignored.
- R6: A data write that arrives while write-ready is low leaves the tables and the index unchanged and sets a sticky error flag at control bit 8. Writing 1 to control bit 8 clears the flag.
- R7: While enable is set, data-port writes leave the tables and the index unchanged.
- R8: The channel-select bits of the address port act as a write mask: bit 8 selects blue, bit 9 green and bit 10 red. A data write updates every selected table. For a read-back, the block picks red first, then green, then blue, and returns 0 when no channel is selected.
- R9: An address write with bit 12 set sets read-ready (control bit 3) when the ready flags return. The data port then reads the selected entry in bits 9:0. The next accepted address write clears read-ready.
- R10: With enable set and reverse-output (control bit 6) set, each output is the bitwise complement of its table entry. With enable clear, reverse-output has no effect on the pass-through.
- R11: Control bits 1, 2 and 7 read back as written. A trailing address write (for example index 0x23) after a load changes no table entry, and the address port reads back the index, mask and flag bits that were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regSel | input | 2 | Port select: 0 control, 1 address, 2 data |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Registered read data |
| pixValid | input | 1 | Input pixel qualifier |
| pixR | input | 8 | Red component in |
| pixG | input | 8 | Green component in |
| pixB | input | 8 | Blue component in |
| outValid | output | 1 | Output pixel qualifier |
| outR | output | 10 | Red component out |
| outG | output | 10 | Green component out |
| outB | output | 10 | Blue component out |

## Verification
The table-write guard can fire in the same cycle that the busy window from the previous write is still open. The bench provokes this by issuing a second data write on the very next cycle after an accepted one. It judges the result by the sticky error bit, by the stored entry at the first index, and by the untouched entry at the next index. A second overlap is the pixel stream running while the host tries to write a table with enable set. Each pixel's expected value goes into a scoreboard queue when the pixel is driven. The check then confirms that the lookups still return the previously loaded curve.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  parameter int PIX_W = 8;
  parameter int OUT_W = 10;
  parameter int BUS_W = 32;
  parameter int NCH   = 3;
  parameter int DEPTH = 1 << PIX_W;
  parameter int SHIFT = OUT_W - PIX_W;

  // channel index order: 0 blue, 1 green, 2 red (matches mask bit order)
  typedef struct packed {
    logic             tblWr;
    logic [NCH-1:0]   chMask;
    logic [PIX_W-1:0] ptr;
    logic [OUT_W-1:0] wdata;
    logic             capture;
    logic             lutEn;
    logic             revOut;
  } strobe_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } port_e;
endpackage

// File: rtl/gamma_ctrl.sv
module gamma_ctrl
  import gamma_pkg::*;
#(
  parameter int BUSY_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [1:0]       regSel,
  input  logic [BUS_W-1:0] regWdata,
  output logic [BUS_W-1:0] regRdata,
  input  logic [OUT_W-1:0] hostWord,
  output strobe_t          stb
);
  localparam int CNT_W    = $clog2(BUSY_CYC + 1);
  localparam int B_EN     = 0;
  localparam int B_SET    = 1;
  localparam int B_TR     = 2;
  localparam int B_REV    = 6;
  localparam int B_VCOM   = 7;
  localparam int B_ERR    = 8;
  localparam int A_MASK   = PIX_W;
  localparam int A_AUTO   = PIX_W + NCH;
  localparam int A_RD     = PIX_W + NCH + 1;

  logic             ctlEn, ctlSet, ctlTr, ctlRev, ctlVcom, errFlag;
  logic [PIX_W-1:0] ptr;
  logic [NCH-1:0]   chMask;
  logic             autoInc, rdReq, readPend, readRdy;
  logic [CNT_W-1:0] busyCnt;
  logic             ready, dataPort, addrPort, ctrlPort;
  logic             acceptData, acceptAddr, captureNow;
  logic [BUS_W-1:0] rdMux;

  assign ready      = (busyCnt == '0);
  assign dataPort   = regWr && (port_e'(regSel) == SEL_DATA);
  assign addrPort   = regWr && (port_e'(regSel) == SEL_ADDR);
  assign ctrlPort   = regWr && (port_e'(regSel) == SEL_CTRL);
  assign acceptData = dataPort && ready && !ctlEn;
  assign acceptAddr = addrPort && ready;
  assign captureNow = readPend && (busyCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      chMask   <= '0;
      autoInc  <= 1'b0;
      rdReq    <= 1'b0;
      readPend <= 1'b0;
      readRdy  <= 1'b0;
      busyCnt  <= '0;
    end else begin
      if (acceptAddr) begin
        ptr      <= regWdata[PIX_W-1:0];
        chMask   <= regWdata[A_MASK +: NCH];
        autoInc  <= regWdata[A_AUTO];
        rdReq    <= regWdata[A_RD];
        readPend <= regWdata[A_RD];
        readRdy  <= 1'b0;
        busyCnt  <= CNT_W'(BUSY_CYC);
      end else if (acceptData) begin
        if (autoInc) ptr <= ptr + 1'b1;
        busyCnt <= CNT_W'(BUSY_CYC);
      end else if (!ready) begin
        busyCnt <= busyCnt - 1'b1;
      end
      if (captureNow) begin
        readPend <= 1'b0;
        readRdy  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlEn   <= 1'b0;
      ctlSet  <= 1'b0;
      ctlTr   <= 1'b0;
      ctlRev  <= 1'b0;
      ctlVcom <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (ctrlPort) begin
        ctlEn   <= regWdata[B_EN];
        ctlSet  <= regWdata[B_SET];
        ctlTr   <= regWdata[B_TR];
        ctlRev  <= regWdata[B_REV];
        ctlVcom <= regWdata[B_VCOM];
        if (regWdata[B_ERR]) errFlag <= 1'b0;
      end
      if (dataPort && !ready) errFlag <= 1'b1;
    end
  end

  always_comb begin
    unique case (port_e'(regSel))
      SEL_CTRL: rdMux = BUS_W'({errFlag, ctlVcom, ctlRev, ready, ready,
                                readRdy, ctlTr, ctlSet, ctlEn});
      SEL_ADDR: rdMux = BUS_W'({rdReq, autoInc, chMask, ptr});
      SEL_DATA: rdMux = BUS_W'(hostWord);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      regRdata <= '0;
    else if (regRd) regRdata <= rdMux;
  end

  always_comb begin
    stb.tblWr   = acceptData;
    stb.chMask  = chMask;
    stb.ptr     = ptr;
    stb.wdata   = regWdata[OUT_W-1:0];
    stb.capture = captureNow;
    stb.lutEn   = ctlEn;
    stb.revOut  = ctlRev;
  end

  assert_wr_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    acceptData |=> !ready);
  assert_addr_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    acceptAddr |=> !ready);
  assert_err_on_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataPort && !ready) |=> errFlag);
  assert_ptr_hold_enabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataPort && ctlEn && !addrPort) |=> $stable(ptr));
  assert_readrdy_with_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readRdy) |-> ready);
endmodule

// File: rtl/gamma_dpath.sv
module gamma_dpath
  import gamma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixR,
  input  logic [PIX_W-1:0] pixG,
  input  logic [PIX_W-1:0] pixB,
  output logic             outValid,
  output logic [OUT_W-1:0] outR,
  output logic [OUT_W-1:0] outG,
  output logic [OUT_W-1:0] outB,
  output logic [OUT_W-1:0] hostWord
);
  logic [PIX_W-1:0] pixIn  [NCH];
  logic [OUT_W-1:0] pixOut [NCH];
  logic [OUT_W-1:0] rdWord [NCH];
  logic [OUT_W-1:0] pickWord;

  assign pixIn[0] = pixB;
  assign pixIn[1] = pixG;
  assign pixIn[2] = pixR;
  assign outB = pixOut[0];
  assign outG = pixOut[1];
  assign outR = pixOut[2];

  for (genvar c = 0; c < NCH; c++) begin : gChan
    logic [OUT_W-1:0] lut [DEPTH];
    logic [OUT_W-1:0] entry;

    always_ff @(posedge clk) begin
      if (stb.tblWr && stb.chMask[c]) lut[stb.ptr] <= stb.wdata;
    end

    assign rdWord[c] = lut[stb.ptr];
    assign entry     = lut[pixIn[c]];

    always_ff @(posedge clk) begin
      if (!rstN) pixOut[c] <= '0;
      else if (pixValid) begin
        if (stb.lutEn) pixOut[c] <= stb.revOut ? ~entry : entry;
        else           pixOut[c] <= {pixIn[c], {SHIFT{1'b0}}};
      end
    end

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rstN)
      (pixValid && !stb.lutEn) |=> pixOut[c] == {$past(pixIn[c]), {SHIFT{1'b0}}});
  end

  always_comb begin
    if (stb.chMask[2])      pickWord = rdWord[2];
    else if (stb.chMask[1]) pickWord = rdWord[1];
    else if (stb.chMask[0]) pickWord = rdWord[0];
    else                    pickWord = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      hostWord <= '0;
    end else begin
      outValid <= pixValid;
      if (stb.capture) hostWord <= pickWord;
    end
  end

  assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);
  assert_write_only_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.tblWr |-> !stb.lutEn);
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_pkg::*;
#(
  parameter int BUSY_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [1:0]       regSel,
  input  logic [BUS_W-1:0] regWdata,
  output logic [BUS_W-1:0] regRdata,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixR,
  input  logic [PIX_W-1:0] pixG,
  input  logic [PIX_W-1:0] pixB,
  output logic             outValid,
  output logic [OUT_W-1:0] outR,
  output logic [OUT_W-1:0] outG,
  output logic [OUT_W-1:0] outB
);
  strobe_t          stb;
  logic [OUT_W-1:0] hostWord;

  gamma_ctrl #(.BUSY_CYC(BUSY_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .hostWord(hostWord), .stb(stb)
  );

  gamma_dpath uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .pixValid(pixValid),
    .pixR(pixR), .pixG(pixG), .pixB(pixB), .outValid(outValid),
    .outR(outR), .outG(outG), .outB(outB), .hostWord(hostWord)
  );
endmodule

// File: tb/tb_gamma_lut.sv
module tb_gamma_lut;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        pixValid = 1'b0;
  logic [7:0]  pixR = '0, pixG = '0, pixB = '0;
  logic        outValid;
  logic [9:0]  outR, outG, outB;

  int tests = 0, fails = 0;
  bit done = 0;
  int mdl [3][256];
  bit mEn = 0, mRev = 0;
  logic [29:0] expQ [$];
  string       tagQ [$];

  always #4 clk = ~clk;

  gamma_lut dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .pixValid(pixValid),
    .pixR(pixR), .pixG(pixG), .pixB(pixB), .outValid(outValid),
    .outR(outR), .outG(outG), .outB(outB)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [1:0] sel, logic [31:0] d);
    regWr = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regSel = 2'd3;
  endtask

  task automatic readReg(logic [1:0] sel, output logic [31:0] d);
    regRd = 1'b1; regSel = sel;
    @(negedge clk);
    regRd = 1'b0; regSel = 2'd3;
    d = regRdata;
  endtask

  task automatic waitRdy();
    logic [31:0] c;
    do readReg(2'd0, c); while (!c[4]);
  endtask

  function automatic logic [31:0] adrWord(bit rd, bit ai, bit [2:0] mask, bit [7:0] p);
    return {19'd0, rd, ai, mask, p};
  endfunction

  function automatic int tblVal(int ch, int i);
    if (ch == 2) return i * 4;
    if (ch == 1) return (255 - i) * 4 + 3;
    return (i * 5 + 9) % 1024;
  endfunction

  task automatic loadChan(int ch);
    writeReg(2'd1, adrWord(0, 1, 3'(1 << ch), 8'd0));
    waitRdy();
    for (int i = 0; i < 256; i++) begin
      writeReg(2'd2, tblVal(ch, i));
      mdl[ch][i] = tblVal(ch, i);
      waitRdy();
    end
  endtask

  task automatic hostRead(bit [2:0] mask, bit [7:0] p, output logic [31:0] v);
    writeReg(2'd1, adrWord(1, 0, mask, p));
    waitRdy();
    readReg(2'd2, v);
  endtask

  function automatic logic [9:0] expComp(int ch, logic [7:0] v);
    logic [9:0] e;
    if (!mEn) return {v, 2'b00};
    e = 10'(mdl[ch][v]);
    return mRev ? ~e : e;
  endfunction

  task automatic sendPix(logic [7:0] r, logic [7:0] g, logic [7:0] b, string tag);
    pixValid = 1'b1; pixR = r; pixG = g; pixB = b;
    expQ.push_back({expComp(2, r), expComp(1, g), expComp(0, b)});
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idlePix(int n);
    pixValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) check("R2 unexpected outValid", 32'd1, 32'd0);
      else begin
        logic [29:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {2'b0, outR, outG, outB}, {2'b0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outValid", {31'd0, outValid}, 0);
    check("R1 outputs", {2'b0, outR, outG, outB}, 0);
    readReg(2'd0, v); check("R1 control", v, 32'h30);
    readReg(2'd1, v); check("R1 address", v, 0);

    // R2 bypass, with gaps
    sendPix(8'd0, 8'd255, 8'd1, "R2 bypass a");
    sendPix(8'd128, 8'd7, 8'd200, "R2 bypass b");
    idlePix(2);
    sendPix(8'd255, 8'd0, 8'd85, "R2 bypass c");
    idlePix(2);

    // R5 ready timing after an address write
    writeReg(2'd1, adrWord(0, 1, 3'b100, 8'd0));
    readReg(2'd0, v); check("R5 busy cycle 1", v[5:4], 2'b00);
    readReg(2'd0, v); check("R5 busy cycle 2", v[5:4], 2'b00);
    readReg(2'd0, v); check("R5 ready again", v[5:4], 2'b11);

    // R4/R8 load all tables
    loadChan(2); loadChan(1); loadChan(0);
    // R11 trailing address write
    writeReg(2'd1, adrWord(0, 1, 3'b001, 8'h23));
    waitRdy();
    readReg(2'd1, v); check("R11 address readback", v, adrWord(0, 1, 3'b001, 8'h23));
    hostRead(3'b001, 8'h23, v); check("R11 entry intact", v, mdl[0][8'h23]);

    // R9 read request / read-ready
    writeReg(2'd1, adrWord(1, 0, 3'b010, 8'd10));
    readReg(2'd0, v); check("R9 readRdy low while busy", v[3], 0);
    waitRdy();
    readReg(2'd0, v); check("R9 readRdy high", v[3], 1);
    readReg(2'd2, v); check("R9 read data", v, mdl[1][10]);
    writeReg(2'd1, adrWord(0, 0, 3'b010, 8'd10));
    waitRdy();
    readReg(2'd0, v); check("R9 readRdy cleared", v[3], 0);

    // R8 multi-channel mask and read priority
    writeReg(2'd1, adrWord(0, 1, 3'b110, 8'd200)); waitRdy();
    writeReg(2'd2, 32'h155); waitRdy();
    mdl[2][200] = 'h155; mdl[1][200] = 'h155;
    hostRead(3'b111, 8'd200, v); check("R8 priority red", v, 'h155);
    hostRead(3'b011, 8'd200, v); check("R8 green written", v, 'h155);
    hostRead(3'b001, 8'd200, v); check("R8 blue untouched", v, mdl[0][200]);
    hostRead(3'b000, 8'd200, v); check("R8 no select", v, 0);

    // R4 wrap and no-increment
    writeReg(2'd1, adrWord(0, 1, 3'b001, 8'd255)); waitRdy();
    writeReg(2'd2, 32'h3A1); waitRdy();
    writeReg(2'd2, 32'h0B2); waitRdy();
    mdl[0][255] = 'h3A1; mdl[0][0] = 'h0B2;
    hostRead(3'b001, 8'd255, v); check("R4 entry 255", v, 'h3A1);
    hostRead(3'b001, 8'd0, v); check("R4 wrap to 0", v, 'h0B2);
    writeReg(2'd1, adrWord(0, 0, 3'b001, 8'd7)); waitRdy();
    writeReg(2'd2, 32'h111); waitRdy();
    writeReg(2'd2, 32'h222); waitRdy();
    mdl[0][7] = 'h222;
    hostRead(3'b001, 8'd7, v); check("R4 fixed index", v, 'h222);
    hostRead(3'b001, 8'd8, v); check("R4 neighbour unchanged", v, mdl[0][8]);

    // R6 write during busy window
    writeReg(2'd1, adrWord(0, 1, 3'b100, 8'd20)); waitRdy();
    writeReg(2'd2, 32'h2AA);
    writeReg(2'd2, 32'h155);
    mdl[2][20] = 'h2AA;
    waitRdy();
    readReg(2'd0, v); check("R6 error set", v[8], 1);
    hostRead(3'b100, 8'd20, v); check("R6 first write kept", v, 'h2AA);
    hostRead(3'b100, 8'd21, v); check("R6 ignored write", v, mdl[2][21]);
    writeReg(2'd0, 32'h100);
    readReg(2'd0, v); check("R6 error cleared", v[8], 0);

    // R3 lookup enabled
    writeReg(2'd0, 32'h1); mEn = 1;
    sendPix(8'd0, 8'd0, 8'd0, "R3 lookup zero");
    sendPix(8'd20, 8'd200, 8'd255, "R3 lookup edited");
    sendPix(8'd255, 8'd128, 8'd7, "R3 lookup mix");
    idlePix(1);
    sendPix(8'd21, 8'd1, 8'd8, "R3 lookup after gap");
    idlePix(2);

    // R7 writes ignored while enabled, pixels streaming alongside
    writeReg(2'd1, adrWord(0, 1, 3'b111, 8'd30)); waitRdy();
    pixValid = 1'b1; pixR = 8'd30; pixG = 8'd30; pixB = 8'd30;
    expQ.push_back({expComp(2, 30), expComp(1, 30), expComp(0, 30)});
    tagQ.push_back("R7 lookup during write");
    writeReg(2'd2, 32'h3FF);
    pixValid = 1'b0;
    waitRdy();
    sendPix(8'd30, 8'd30, 8'd30, "R7 table unchanged");
    idlePix(2);
    readReg(2'd1, v); check("R7 index held", v[7:0], 8'd30);

    // R10 reverse output
    writeReg(2'd0, 32'h41); mRev = 1;
    sendPix(8'd5, 8'd250, 8'd100, "R10 reversed");
    idlePix(2);
    writeReg(2'd0, 32'h40); mEn = 0;
    sendPix(8'd5, 8'd250, 8'd100, "R10 bypass ignores reverse");
    idlePix(2);

    // R11 plain R/W bits
    writeReg(2'd0, 32'h86);
    readReg(2'd0, v); check("R11 control bits", v, 32'hB6);

    check("R2 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule